// File: doc/BRIEF.md
# Receive Descriptor Frame Writer

This block moves received frames from a byte stream into memory buffers that software hands over through a linked list of descriptors. Each descriptor is four 32-bit words: a status/length word at offset 0, the buffer start address at offset 4, an unused word at offset 8 and the address of the next descriptor at offset 12. The block reads the current descriptor and checks that the MAC owns it. It then packs the arriving bytes into words and writes them into the buffer. When the frame ends, it writes the length and status back into the descriptor, returns ownership to software and follows the link word to the next descriptor.

Software controls the block through a few level inputs: the list start address, a receive enable, a long-frame accept switch and an interrupt enable mask. A one-cycle poll request restarts fetching after the block stopped on a software-owned descriptor. A one-cycle clear vector clears interrupt status bits, one bit per status bit. The block reports the current descriptor address, the sticky interrupt status bits and one interrupt line.

Top module: `rx_desc_writer`

## Requirements
- R1: After reset, curDesc is 0, intStatus is 0, rxIrq is 0, inReady is 0 and memReq is 0.
- R2: While rxOn is low after reset, no memory request is made. The first time rxOn is high, curDesc is loaded from listStart and the status word at curDesc is read.
- R3: A descriptor is used only when bits 31:30 of its status word read 2'b10 (MAC owned). Its buffer address is read at offset +4 and its link at offset +12. A memory request holds its address and direction until memAck.
- R4: Received bytes are packed little-endian: byte n of the frame goes to bits 8*(n%4)+7 : 8*(n%4) of the word at buffer + 4*(n/4). A final partial word is written with memBe set only for the lanes it holds. inReady is never high while a memory request is pending.
- R5: After a good frame, the status word written at curDesc holds 2'b00 in bits 31:30, 1 in bit 20 and intEnable[0] in bit 16. Bits 15:0 hold the frame byte count plus 4.
- R6: After the status write, curDesc takes the link word value and the next descriptor is fetched.
- R7: A completed frame sets intStatus bits 0, 4 and 9. rxIrq is the OR of intStatus AND intEnable. A 1 in statusClr clears the matching intStatus bit.
- R8: With acceptLong high, a frame longer than 1518 bytes is stored in full. Its status word also has bit 19 set, and intStatus bit 3 is set.
- R9: With acceptLong low, a frame longer than 1518 bytes is dropped. No status write is made and curDesc does not change. Only intStatus bit 3 is set, and the same descriptor receives the next frame.
- R10: A descriptor whose owner field is not 2'b10 halts reception: intStatus bit 10 is set and inReady stays low. A pollDemand pulse fetches the descriptor again.
- R11: A pollDemand pulse while a descriptor is already in use has no effect on the stored data, the status word or the interrupt status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| listStart | input | 32 | Address of the first descriptor |
| rxOn | input | 1 | Receive enable |
| acceptLong | input | 1 | Store frames longer than the maximum length |
| intEnable | input | 16 | Interrupt enable mask; bit 0 also selects descriptor bit 16 |
| statusClr | input | 16 | One-cycle clear pulses for intStatus bits |
| pollDemand | input | 1 | Refetch request after a halt |
| inValid | input | 1 | Stream byte valid |
| inData | input | 8 | Stream byte |
| inLast | input | 1 | Marks the last byte of a frame |
| inReady | output | 1 | Stream byte accepted when high with inValid |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | Memory write (1) or read (0) |
| memAddr | output | 32 | Byte address, word aligned |
| memWdata | output | 32 | Write data |
| memBe | output | 4 | Write byte enables |
| memRdata | input | 32 | Read data, valid with memAck |
| memAck | input | 1 | Completes the current request |
| curDesc | output | 32 | Current descriptor address |
| intStatus | output | 16 | Sticky interrupt status (bits 0, 3, 4, 9, 10 used) |
| rxIrq | output | 1 | Receive interrupt line |

## Verification
The bench sends a 5-byte frame to test the partial trailing word. If byte enables were wrong, the prefilled lanes of that word would be overwritten. It sends a 1520-byte frame with long frames refused and a 1600-byte frame with them accepted. A design that wrote status on the dropped frame or advanced the descriptor would show a changed owner field or curDesc, and a missing bit 19 or a truncated buffer would expose a wrong accept path. A software-owned descriptor must halt reception until a poll, and a poll sent mid-use must change nothing. Reported lengths are compared against the byte count plus 4, so an off-by-one in the counter or the CRC adjustment shows up directly.

// File: rtl/rxdw_pkg.sv
package rxdw_pkg;
  localparam int LEN_W = 16;
  localparam int LANES = 4;
  localparam int DESC_STAT_OFS = 0;
  localparam int DESC_BUF_OFS = 4;
  localparam int DESC_LINK_OFS = 12;
  localparam logic [1:0] OWN_MAC = 2'b10;
  localparam logic [1:0] OWN_CPU = 2'b00;
  // interrupt status bit positions
  localparam int ST_RXINT = 0;
  localparam int ST_LONG = 3;
  localparam int ST_GOOD = 4;
  localparam int ST_EARLY = 9;
  localparam int ST_NODESC = 10;

  typedef enum logic [2:0] {
    MEM_NONE, MEM_RD_STAT, MEM_RD_BUF, MEM_RD_LINK, MEM_WR_DATA, MEM_WR_STAT
  } memOp_t;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_BUFA, S_LINK, S_RECV, S_WDATA, S_WSTAT, S_HALT
  } state_t;

  typedef struct packed {
    logic loadList;
    logic capBuf;
    logic capLink;
    logic advance;
    logic takeByte;
    logic wordDone;
    logic frameReset;
    memOp_t op;
  } dpCtl_t;

  typedef struct packed {
    logic wordReady;
    logic lastSeen;
    logic overLen;
  } dpFlags_t;
endpackage

// File: rtl/rxdw_datapath.sv
module rxdw_datapath
  import rxdw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int MAX_FRAME = 1518,
  parameter int CRC_BYTES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] listStart,
  input  logic              acceptLong,
  input  logic              intEnRx,
  input  logic [7:0]        inData,
  input  logic              inLast,
  input  dpCtl_t            ctl,
  input  logic [31:0]       memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  output logic [3:0]        memBe,
  output logic [ADDR_W-1:0] curDesc,
  output dpFlags_t          flags
);
  localparam int FILL_W = $clog2(LANES + 1);
  localparam int WIDX_W = LEN_W - 2;

  logic [ADDR_W-1:0] curDescQ, bufBase, linkAddr;
  logic [31:0]       packWord;
  logic [LANES-1:0]  laneEn;
  logic [FILL_W-1:0] fill;
  logic [WIDX_W-1:0] wordIdx;
  logic [LEN_W-1:0]  byteCnt;
  logic              lastSeen, overLen;
  logic              storeByte, pastMax;
  logic [LEN_W-1:0]  lenOut;
  logic [31:0]       statusWord;

  assign pastMax   = byteCnt >= LEN_W'(MAX_FRAME);
  assign storeByte = acceptLong || !pastMax;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curDescQ <= '0;
      bufBase  <= '0;
      linkAddr <= '0;
      packWord <= '0;
      laneEn   <= '0;
      fill     <= '0;
      wordIdx  <= '0;
      byteCnt  <= '0;
      lastSeen <= 1'b0;
      overLen  <= 1'b0;
    end else begin
      if (ctl.loadList) curDescQ <= listStart;
      else if (ctl.advance) curDescQ <= linkAddr;
      if (ctl.capBuf) bufBase <= memRdata[ADDR_W-1:0];
      if (ctl.capLink) linkAddr <= memRdata[ADDR_W-1:0];
      if (ctl.frameReset) begin
        laneEn   <= '0;
        fill     <= '0;
        wordIdx  <= '0;
        byteCnt  <= '0;
        lastSeen <= 1'b0;
        overLen  <= 1'b0;
      end else if (ctl.takeByte) begin
        byteCnt  <= byteCnt + 1'b1;
        lastSeen <= inLast;
        if (pastMax) overLen <= 1'b1;
        if (storeByte) begin
          packWord[8*fill[1:0] +: 8] <= inData;
          laneEn[fill[1:0]]          <= 1'b1;
          fill                       <= fill + 1'b1;
        end
      end else if (ctl.wordDone) begin
        laneEn  <= '0;
        fill    <= '0;
        wordIdx <= wordIdx + 1'b1;
      end
    end
  end

  assign lenOut = byteCnt + LEN_W'(CRC_BYTES);
  assign statusWord = {OWN_CPU, 9'b0, 1'b1, overLen, 2'b0, intEnRx, lenOut};

  always_comb begin
    memAddr  = curDescQ + ADDR_W'(DESC_STAT_OFS);
    memWdata = statusWord;
    memBe    = 4'hF;
    case (ctl.op)
      MEM_RD_BUF:  memAddr = curDescQ + ADDR_W'(DESC_BUF_OFS);
      MEM_RD_LINK: memAddr = curDescQ + ADDR_W'(DESC_LINK_OFS);
      MEM_WR_DATA: begin
        memAddr  = bufBase + ADDR_W'({wordIdx, 2'b00});
        memWdata = packWord;
        memBe    = laneEn;
      end
      default: ;
    endcase
  end

  assign curDesc = curDescQ;
  assign flags.wordReady = (fill == FILL_W'(LANES)) || (lastSeen && fill != '0);
  assign flags.lastSeen  = lastSeen;
  assign flags.overLen   = overLen;
endmodule

// File: rtl/rxdw_ctrl.sv
module rxdw_ctrl
  import rxdw_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        rxOn,
  input  logic        acceptLong,
  input  logic        pollDemand,
  input  logic        inValid,
  input  logic        memAck,
  input  logic [1:0]  rdOwner,
  input  dpFlags_t    flags,
  input  logic [15:0] intEnable,
  input  logic [15:0] statusClr,
  output dpCtl_t      ctl,
  output logic        inReady,
  output logic        memReq,
  output logic        memWe,
  output logic [15:0] intStatus,
  output logic        rxIrq
);
  state_t      state, nextState;
  logic        started;
  logic [15:0] stReg, setBits;

  always_comb begin
    ctl       = '0;
    nextState = state;
    setBits   = '0;
    case (state)
      S_IDLE: if (rxOn) begin
        ctl.loadList = !started;
        nextState    = S_FETCH;
      end
      S_FETCH: begin
        ctl.op = MEM_RD_STAT;
        if (memAck) begin
          if (rdOwner == OWN_MAC) nextState = S_BUFA;
          else begin
            setBits[ST_NODESC] = 1'b1;
            nextState          = S_HALT;
          end
        end
      end
      S_BUFA: begin
        ctl.op = MEM_RD_BUF;
        if (memAck) begin
          ctl.capBuf = 1'b1;
          nextState  = S_LINK;
        end
      end
      S_LINK: begin
        ctl.op = MEM_RD_LINK;
        if (memAck) begin
          ctl.capLink    = 1'b1;
          ctl.frameReset = 1'b1;
          nextState      = S_RECV;
        end
      end
      S_RECV: begin
        if (flags.wordReady) nextState = S_WDATA;
        else if (flags.lastSeen) begin
          if (flags.overLen && !acceptLong) begin
            setBits[ST_LONG] = 1'b1;
            ctl.frameReset   = 1'b1;
          end else nextState = S_WSTAT;
        end else ctl.takeByte = inValid;
      end
      S_WDATA: begin
        ctl.op = MEM_WR_DATA;
        if (memAck) begin
          ctl.wordDone = 1'b1;
          nextState    = S_RECV;
        end
      end
      S_WSTAT: begin
        ctl.op = MEM_WR_STAT;
        if (memAck) begin
          ctl.advance        = 1'b1;
          setBits[ST_RXINT]  = 1'b1;
          setBits[ST_GOOD]   = 1'b1;
          setBits[ST_EARLY]  = 1'b1;
          setBits[ST_LONG]   = flags.overLen;
          nextState          = rxOn ? S_FETCH : S_IDLE;
        end
      end
      S_HALT: begin
        if (!rxOn) nextState = S_IDLE;
        else if (pollDemand) nextState = S_FETCH;
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      started <= 1'b0;
      stReg   <= '0;
    end else begin
      state <= nextState;
      if (ctl.loadList) started <= 1'b1;
      stReg <= (stReg & ~statusClr) | setBits;
    end
  end

  assign inReady   = (state == S_RECV) && !flags.wordReady && !flags.lastSeen;
  assign memReq    = ctl.op != MEM_NONE;
  assign memWe     = (ctl.op == MEM_WR_DATA) || (ctl.op == MEM_WR_STAT);
  assign intStatus = stReg;
  assign rxIrq     = |(stReg & intEnable);
endmodule

// File: rtl/rx_desc_writer.sv
module rx_desc_writer
  import rxdw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int MAX_FRAME = 1518,
  parameter int CRC_BYTES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] listStart,
  input  logic              rxOn,
  input  logic              acceptLong,
  input  logic [15:0]       intEnable,
  input  logic [15:0]       statusClr,
  input  logic              pollDemand,
  input  logic              inValid,
  input  logic [7:0]        inData,
  input  logic              inLast,
  output logic              inReady,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  output logic [3:0]        memBe,
  input  logic [31:0]       memRdata,
  input  logic              memAck,
  output logic [ADDR_W-1:0] curDesc,
  output logic [15:0]       intStatus,
  output logic              rxIrq
);
  dpCtl_t   ctl;
  dpFlags_t flags;

  rxdw_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .rxOn(rxOn), .acceptLong(acceptLong),
    .pollDemand(pollDemand), .inValid(inValid), .memAck(memAck),
    .rdOwner(memRdata[31:30]), .flags(flags), .intEnable(intEnable),
    .statusClr(statusClr), .ctl(ctl), .inReady(inReady), .memReq(memReq),
    .memWe(memWe), .intStatus(intStatus), .rxIrq(rxIrq)
  );

  rxdw_datapath #(.ADDR_W(ADDR_W), .MAX_FRAME(MAX_FRAME), .CRC_BYTES(CRC_BYTES)) i_dp (
    .clk(clk), .rstN(rstN), .listStart(listStart), .acceptLong(acceptLong),
    .intEnRx(intEnable[0]), .inData(inData), .inLast(inLast), .ctl(ctl),
    .memRdata(memRdata), .memAddr(memAddr), .memWdata(memWdata),
    .memBe(memBe), .curDesc(curDesc), .flags(flags)
  );
endmodule

// File: rtl/rx_desc_writer_chk.sv
module rx_desc_writer_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              inReady,
  input logic              memReq,
  input logic              memWe,
  input logic              memAck,
  input logic [ADDR_W-1:0] memAddr,
  input logic [31:0]       memWdata,
  input logic [3:0]        memBe,
  input logic [31:0]       memRdata,
  input logic [ADDR_W-1:0] curDesc,
  input logic [15:0]       intStatus
);
  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memWe));

  assert_no_byte_during_mem_R4: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> !memReq);

  assert_write_has_lanes_R4: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWe |-> memBe != 4'h0);

  assert_stat_handback_R5: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWe && memAck && memAddr == curDesc |->
      memWdata[31:30] == 2'b00 && memWdata[20] && memBe == 4'hF);

  assert_good_after_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intStatus[4]) |-> $past(memReq && memWe && memAck));

  assert_nodesc_on_cpu_owner_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intStatus[10]) |-> $past(memReq && !memWe && memAck && memRdata[31:30] != 2'b10));
endmodule

bind rx_desc_writer rx_desc_writer_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rstN(rstN), .inReady(inReady), .memReq(memReq), .memWe(memWe),
  .memAck(memAck), .memAddr(memAddr), .memWdata(memWdata), .memBe(memBe),
  .memRdata(memRdata), .curDesc(curDesc), .intStatus(intStatus)
);

// File: tb/test_rx_desc_writer.sv
module test_rx_desc_writer;
  logic        clk = 1'b0;
  logic        rstN;
  logic [31:0] listStart;
  logic        rxOn, acceptLong, pollDemand;
  logic [15:0] intEnable, statusClr;
  logic        inValid, inLast, inReady;
  logic [7:0]  inData;
  logic        memReq, memWe, memAck;
  logic [31:0] memAddr, memWdata, memRdata, curDesc;
  logic [3:0]  memBe;
  logic [15:0] intStatus;
  logic        rxIrq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] mem [0:4095];

  always #10 clk = ~clk;

  rx_desc_writer i_rx_desc_writer (
    .clk(clk), .rstN(rstN), .listStart(listStart), .rxOn(rxOn),
    .acceptLong(acceptLong), .intEnable(intEnable), .statusClr(statusClr),
    .pollDemand(pollDemand), .inValid(inValid), .inData(inData),
    .inLast(inLast), .inReady(inReady), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memBe(memBe),
    .memRdata(memRdata), .memAck(memAck), .curDesc(curDesc),
    .intStatus(intStatus), .rxIrq(rxIrq)
  );

  assign memRdata = mem[memAddr[13:2]];

  always @(posedge clk) begin
    if (!rstN) memAck <= 1'b0;
    else begin
      memAck <= memReq && !memAck;
      if (memReq && memAck && memWe)
        for (int b = 0; b < 4; b++)
          if (memBe[b]) mem[memAddr[13:2]][8*b +: 8] <= memWdata[8*b +: 8];
    end
  end

  function automatic logic [7:0] patt(input int seed, input int i);
    return 8'(seed + i * 7 + i / 256);
  endfunction

  function automatic logic [31:0] pattWord(input int seed, input int k);
    return {patt(seed, 4*k+3), patt(seed, 4*k+2), patt(seed, 4*k+1), patt(seed, 4*k)};
  endfunction

  task automatic chkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic sendFrame(input int len, input int seed);
    for (int i = 0; i < len; i++) begin
      inData  = patt(seed, i);
      inLast  = (i == len - 1);
      inValid = 1'b1;
      while (!inReady) @(negedge clk);
      @(negedge clk);
    end
    inValid = 1'b0;
    inLast  = 1'b0;
  endtask

  task automatic waitCur(input logic [31:0] exp);
    int n = 0;
    while (curDesc !== exp && n < 20000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic pulseClear();
    statusClr = 16'hFFFF;
    @(negedge clk);
    statusClr = 16'h0000;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int bad;
    int reqSeen;
    rstN = 1'b0; rxOn = 1'b0; acceptLong = 1'b0; pollDemand = 1'b0;
    intEnable = 16'h0; statusClr = 16'h0; listStart = 32'h100;
    inValid = 1'b0; inLast = 1'b0; inData = 8'h0;
    for (int w = 0; w < 4096; w++) mem[w] = 32'hDEADBEEF;
    // desc0 at 0x100, desc1 at 0x110, desc2 at 0x120 (CPU owned)
    mem[32'h40] = 32'h8000_0000; mem[32'h41] = 32'h1000; mem[32'h42] = 0; mem[32'h43] = 32'h110;
    mem[32'h44] = 32'h8000_0000; mem[32'h45] = 32'h2000; mem[32'h46] = 0; mem[32'h47] = 32'h120;
    mem[32'h48] = 32'h0000_0000; mem[32'h49] = 32'h1000; mem[32'h4A] = 0; mem[32'h4B] = 32'h100;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    chkEq("R1 curDesc", curDesc, 32'h0);
    chkEq("R1 intStatus", {16'h0, intStatus}, 32'h0);
    chkEq("R1 rxIrq/inReady/memReq", {29'h0, rxIrq, inReady, memReq}, 32'h0);

    reqSeen = 0;
    repeat (10) begin
      @(negedge clk);
      if (memReq) reqSeen++;
    end
    chkEq("R2 no request while off", reqSeen, 0);

    // frame 1: 5 bytes, interrupts disabled
    rxOn = 1'b1;
    sendFrame(5, 8'h10);
    waitCur(32'h110);
    repeat (2) @(negedge clk);
    chkEq("R4 full word", mem[32'h400], pattWord(8'h10, 0));
    chkEq("R4 partial word lanes", mem[32'h401], {24'hDEADBE, patt(8'h10, 4)});
    chkEq("R5 status word len 5", mem[32'h40], 32'h0010_0009);
    chkEq("R6 curDesc follows link", curDesc, 32'h110);
    chkEq("R7 status bits", {16'h0, intStatus}, 32'h0211);
    chkEq("R7 irq masked", {31'h0, rxIrq}, 32'h0);
    pulseClear();
    chkEq("R7 clear", {15'h0, rxIrq, intStatus}, 32'h0);

    // frame 2: 64 bytes, poll during use, receive interrupt enabled
    intEnable = 16'h0001;
    repeat (10) @(negedge clk);
    pollDemand = 1'b1;
    @(negedge clk);
    pollDemand = 1'b0;
    sendFrame(64, 8'h33);
    waitCur(32'h120);
    repeat (20) @(negedge clk);
    bad = 0;
    for (int k = 0; k < 16; k++) if (mem[32'h800 + k] !== pattWord(8'h33, k)) bad++;
    chkEq("R4 R11 64-byte buffer mismatches", bad, 0);
    chkEq("R5 R11 status word len 64", mem[32'h44], 32'h0011_0044);
    chkEq("R10 R7 status with halt", {16'h0, intStatus}, 32'h0611);
    chkEq("R7 irq enabled", {31'h0, rxIrq}, 32'h1);
    bad = 0;
    repeat (30) begin
      @(negedge clk);
      if (inReady) bad++;
    end
    chkEq("R10 halted no ready", bad, 0);

    // hand desc2 to the MAC and poll; drop a too-long frame
    mem[32'h48] = 32'h8000_0000;
    pulseClear();
    pollDemand = 1'b1;
    @(negedge clk);
    pollDemand = 1'b0;
    sendFrame(1520, 8'h55);
    repeat (20) @(negedge clk);
    chkEq("R9 no status write", mem[32'h48], 32'h8000_0000);
    chkEq("R9 no advance", curDesc, 32'h120);
    chkEq("R9 only long bit", {16'h0, intStatus}, 32'h0008);

    // accept a 1600-byte frame into the same descriptor
    pulseClear();
    acceptLong = 1'b1;
    sendFrame(1600, 8'h77);
    waitCur(32'h100);
    repeat (20) @(negedge clk);
    chkEq("R8 long status word", mem[32'h48], 32'h0019_0644);
    bad = 0;
    for (int k = 0; k < 400; k++) if (mem[32'h400 + k] !== pattWord(8'h77, k)) bad++;
    chkEq("R8 long buffer mismatches", bad, 0);
    chkEq("R8 R10 status bits", {16'h0, intStatus}, 32'h0619);
    chkEq("R6 wrap link", curDesc, 32'h100);

    summary();
    $finish;
  end
endmodule